// File: doc/BRIEF.md
# Prefixed Load/Store Effective Address Generator

This unit computes the 64-bit effective address of a two-word prefixed load or store. The first instruction word (the prefix) carries the upper 18 bits of a 34-bit signed displacement and a flag that selects a PC-relative address. The second word (the suffix) carries the lower 16 displacement bits and a 5-bit base register index. The unit sends that index straight out to the register-file read port. It then adds the returned base value, the current instruction address, or nothing to the sign-extended displacement. The flag combined with a nonzero base index is not a legal encoding, and the unit reports it as an invalid form.

The result can go through one pipeline stage, selected by a parameter. In that stage the address and the invalid flag are captured together with a valid bit. The stage loads only when an input is presented and otherwise holds its contents. Register reads, memory access, translation and alignment checking are done elsewhere.

Top module: `pfx_ea_gen`

## Requirements
- R1: The displacement is the 34-bit value {prefix[17:0], suffix[15:0]}. It is sign-extended to 64 bits, with bit 33 as the sign bit.
- R2: `base_idx` equals suffix[20:16] in the same cycle, combinationally.
- R3: When prefix[20]=0 and the base index is nonzero, the address is `base_val` plus the displacement.
- R4: When prefix[20]=0 and the base index is 0, the address is the displacement alone, and `base_val` has no effect.
- R5: When prefix[20]=1 and the base index is 0, the address is `pc` plus the displacement.
- R6: When prefix[20]=1 and the base index is nonzero, `invalid_form` is 1 and the reported address is 0.
- R7: Address addition wraps modulo 2^64.
- R8: With the output stage enabled (the default), the address and flag for an input presented with `in_valid`=1 appear on the next clock edge, with `out_valid`=1. Reset clears `out_valid`, `ea` and `invalid_form` to 0.
- R9: A cycle with `in_valid`=0 gives `out_valid`=0 on the next edge and leaves `ea` and `invalid_form` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Prefix/suffix pair is presented this cycle |
| prefix_word | input | 32 | First instruction word |
| suffix_word | input | 32 | Second instruction word |
| base_val | input | 64 | Value read from the base register |
| pc | input | 64 | Address of the prefixed instruction |
| base_idx | output | 5 | Base register index for the read port |
| ea | output | 64 | Effective address |
| invalid_form | output | 1 | Illegal PC-relative form with nonzero base |
| out_valid | output | 1 | `ea` and `invalid_form` are valid |

## Verification
`base_idx` is combinational, so the bench samples it shortly after it drives the inputs, in the same cycle. The address, the invalid flag and `out_valid` come out of one register stage. They are due on the first rising edge after the input is driven, and the bench samples them at the falling edge that follows. The hold behaviour is checked one cycle after `in_valid` drops: the outputs must still carry the last result while `out_valid` is 0.

// File: rtl/pea_pkg.sv
package pea_pkg;
    localparam int DISP_W      = 34;
    localparam int DHI_W       = 18;
    localparam int DLO_W       = 16;
    localparam int IDX_W       = 5;
    localparam int PCREL_BIT   = 20;
    localparam int IDX_LSB     = 16;

    typedef struct packed {
        logic             pcrel;
        logic [IDX_W-1:0] idx;
        logic [DHI_W-1:0] dhi;
        logic [DLO_W-1:0] dlo;
    } pea_fields_t;
endpackage

// File: rtl/pea_field_decode.sv
module pea_field_decode
    import pea_pkg::*;
(
    input  logic [PCREL_BIT:0]          pfx_low,
    input  logic [IDX_LSB+IDX_W-1:0]    sfx_low,
    output pea_fields_t                 fields
);
    logic unused_pfx;
    assign unused_pfx = pfx_low[19] ^ pfx_low[18];

    always_comb begin
        fields.pcrel = pfx_low[PCREL_BIT];
        fields.idx   = sfx_low[IDX_LSB +: IDX_W];
        fields.dhi   = pfx_low[DHI_W-1:0];
        fields.dlo   = sfx_low[DLO_W-1:0];
    end
endmodule

// File: rtl/pea_addr_calc.sv
module pea_addr_calc
    import pea_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  pea_fields_t        fields,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  addr,
    output logic               bad_form
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base_sel;
    logic              idx_nz;

    always_comb begin
        disp     = {fields.dhi, fields.dlo};
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        idx_nz   = |fields.idx;
        bad_form = fields.pcrel && idx_nz;
        unique case ({fields.pcrel, idx_nz})
            2'b01:   base_sel = base_val;
            2'b10:   base_sel = pc;
            default: base_sel = '0;
        endcase
        addr = bad_form ? '0 : (base_sel + disp_ext);
    end
endmodule

// File: rtl/pfx_ea_gen.sv
module pfx_ea_gen
    import pea_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       prefix_word,
    input  logic [31:0]       suffix_word,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  base_idx,
    output logic [ADDR_W-1:0] ea,
    output logic              invalid_form,
    output logic              out_valid
);
    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    pea_fields_t       fields;
    logic [ADDR_W-1:0] addr_c;
    logic              bad_c;
    logic              unused_hi;

    assign unused_hi = ^{prefix_word[31:21], suffix_word[31:21]};

    pea_field_decode u_dec (
        .pfx_low (prefix_word[PCREL_BIT:0]),
        .sfx_low (suffix_word[IDX_LSB+IDX_W-1:0]),
        .fields  (fields)
    );

    pea_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
        .fields   (fields),
        .base_val (base_val),
        .pc       (pc),
        .addr     (addr_c),
        .bad_form (bad_c)
    );

    assign base_idx = fields.idx;

    generate
        if (REG_OUT) begin : g_reg
            stage_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                st_d.vld = in_valid;
                if (in_valid) begin
                    st_d.bad  = bad_c;
                    st_d.addr = addr_c;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign ea           = st_q.addr;
            assign invalid_form = st_q.bad;
            assign out_valid    = st_q.vld;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk   = clk ^ rst_n;
            assign ea           = addr_c;
            assign invalid_form = bad_c;
            assign out_valid    = in_valid;
        end
    endgenerate
endmodule

// File: rtl/pfx_ea_gen_chk.sv
module pfx_ea_gen_chk #(
    parameter int ADDR_W  = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       prefix_word,
    input logic [31:0]       suffix_word,
    input logic [ADDR_W-1:0] ea,
    input logic              invalid_form,
    input logic              out_valid
);
    generate
        if (REG_OUT) begin : g_chk
            // R6: an illegal form never reports an address
            assert_bad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && invalid_form) |-> (ea == '0));

            // R6: the illegal encoding raises the flag one cycle later
            assert_bad_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && prefix_word[20] && (suffix_word[20:16] != 5'd0)) |=> invalid_form);

            // R8: an accepted input yields a valid result on the next edge
            assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            // R9: no input means no valid result, and the outputs hold
            assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(ea) && $stable(invalid_form)));

            // R4: the legal zero-base, non-PC form never raises the flag
            assert_zero_base_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !prefix_word[20] && (suffix_word[20:16] == 5'd0)) |=> !invalid_form);
        end
    endgenerate
endmodule

bind pfx_ea_gen pfx_ea_gen_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .prefix_word  (prefix_word),
    .suffix_word  (suffix_word),
    .ea           (ea),
    .invalid_form (invalid_form),
    .out_valid    (out_valid)
);

// File: tb/pfx_ea_gen_test.sv
module pfx_ea_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] prefix_word = '0;
    logic [31:0] suffix_word = '0;
    logic [63:0] base_val = '0;
    logic [63:0] pc = '0;
    logic [4:0]  base_idx;
    logic [63:0] ea;
    logic        invalid_form;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfx_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .prefix_word(prefix_word), .suffix_word(suffix_word),
        .base_val(base_val), .pc(pc), .base_idx(base_idx),
        .ea(ea), .invalid_form(invalid_form), .out_valid(out_valid)
    );

    typedef struct packed {
        logic        r;
        logic [4:0]  ra;
        logic [17:0] dhi;
        logic [15:0] dlo;
        logic [63:0] base;
        logic [63:0] pcv;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd5,  18'h00000, 16'h0100, 64'h0000_0000_0000_1000, 64'h0},
        '{1'b0, 5'd0,  18'h00000, 16'h0100, 64'hDEAD_BEEF_0000_0000, 64'h0},
        '{1'b1, 5'd0,  18'h3FFFF, 16'hFFF0, 64'h5555, 64'h0000_0000_0000_4000},
        '{1'b1, 5'd3,  18'h00010, 16'h0004, 64'h1234, 64'h8000},
        '{1'b0, 5'd31, 18'h20000, 16'h0000, 64'h0000_0004_0000_0000, 64'h0},
        '{1'b0, 5'd1,  18'h1FFFF, 16'hFFFF, 64'h0, 64'h0},
        '{1'b0, 5'd2,  18'h00000, 16'h0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{1'b1, 5'd0,  18'h00001, 16'h0000, 64'h0, 64'hFFFF_FFFF_FFFF_0000}
    };
    localparam string TAGS [NV] = '{"R3", "R4", "R5", "R6", "R1", "R1", "R7", "R7"};

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_ea(input vec_t v);
        logic [33:0] d;
        logic [63:0] dx;
        d  = {v.dhi, v.dlo};
        dx = {{30{d[33]}}, d};
        if (v.r && v.ra != 0) return 64'h0;
        if (v.r)              return v.pcv + dx;
        if (v.ra != 0)        return v.base + dx;
        return dx;
    endfunction

    task automatic drive(input vec_t v);
        prefix_word = 32'h0400_0000 | ({31'd0, v.r} << 20) | {14'd0, v.dhi};
        suffix_word = 32'hE000_0000 | (32'd7 << 21) | ({27'd0, v.ra} << 16) | {16'd0, v.dlo};
        base_val    = v.base;
        pc          = v.pcv;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R8: reset state
        check("R8", {63'd0, out_valid}, 64'd0);
        check("R8", ea, 64'd0);
        check("R8", {63'd0, invalid_form}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            #1;
            check("R2", {59'd0, base_idx}, {59'd0, VECS[i].ra});
            @(negedge clk);
            check("R8", {63'd0, out_valid}, 64'd1);
            check(TAGS[i], ea, model_ea(VECS[i]));
            check(TAGS[i], {63'd0, invalid_form}, {63'd0, (VECS[i].r && VECS[i].ra != 0)});
        end

        // R1: hand-computed sign-extension extremes
        drive('{1'b0, 5'd0, 18'h20000, 16'h0000, 64'h0, 64'h0});
        @(negedge clk);
        check("R1", ea, 64'hFFFF_FFFE_0000_0000);
        drive('{1'b0, 5'd0, 18'h1FFFF, 16'hFFFF, 64'h0, 64'h0});
        @(negedge clk);
        check("R1", ea, 64'h0000_0001_FFFF_FFFF);

        // R4: base value has no effect when index is zero
        drive('{1'b0, 5'd0, 18'h00000, 16'h0040, 64'hFFFF_0000_FFFF_0000, 64'h7777});
        @(negedge clk);
        check("R4", ea, 64'h40);

        // R6: illegal form after a legal one gives zero address and flag
        drive('{1'b1, 5'd9, 18'h00000, 16'h0040, 64'h100, 64'h200});
        @(negedge clk);
        check("R6", ea, 64'h0);
        check("R6", {63'd0, invalid_form}, 64'd1);

        // R9: idle cycle holds outputs, new inputs ignored
        drive('{1'b0, 5'd4, 18'h00000, 16'h0008, 64'h1000, 64'h0});
        @(negedge clk);
        check("R3", ea, 64'h1008);
        in_valid = 1'b0;
        drive('{1'b1, 5'd2, 18'h00000, 16'h0001, 64'h0, 64'h0});
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0);
        check("R9", ea, 64'h1008);
        check("R9", {63'd0, invalid_form}, 64'd0);
        @(negedge clk);
        check("R9", ea, 64'h1008);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule